// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is the transmit half of a register-driven I2C bus master. A host opens a transaction by writing the bus-busy and start/stop control bits to 1 while the bus is idle; the engine then pulls SDA low while SCL is high and afterwards pulls SCL low. Each byte after that is sent in the same way. The host writes the data register and then clears the transfer-complete flag. The engine shifts the byte out MSB first over eight SCL clocks. On a ninth clock it releases SDA and samples the acknowledge. At the rising edge of that ninth clock it sets the completion flag. It then parks with SCL held low until the host supplies the next byte. The first byte after a start is normally the 7-bit slave address followed by the read/write direction bit. The engine does not interpret it.

The host reads the acknowledge status bit (0 = acknowledged, 1 = not acknowledged) to decide whether to continue. It ends the transaction by writing both control bits to 0. The engine then drives SDA low, releases SCL, and releases SDA while SCL is high, which forms a stop condition. SCL and SDA are open-drain lines. They are modelled as drive-low enables plus line inputs. The SCL line input also lets a slave stretch the high phase of a data clock.

States: `S_IDLE` (lines released), `S_START_A` (SDA low, SCL high), `S_START_B` (SCL low), `S_HOLD` (SCL parked low), `S_BIT_LOW` / `S_BIT_HIGH` (the two halves of each of the nine clocks), and `S_STOP_A` (SDA low, SCL low), `S_STOP_B` (SCL released), `S_STOP_C` (SDA released). Transitions:
- IDLE→START_A happens on a start request.
- START_A→START_B→HOLD and the STOP_A→STOP_B→STOP_C→IDLE steps each happen when their phase timer runs out.
- HOLD→BIT_LOW happens on a flag clear that follows a data write.
- HOLD→STOP_A happens on a stop request.
- BIT_LOW→BIT_HIGH happens when the low phase runs out.
- BIT_HIGH→BIT_LOW happens when the high phase runs out, or BIT_HIGH→HOLD after the ninth clock.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset the engine is idle: SCL and SDA are both released, the completion flag is 0, the acknowledge status is 0 and bus-busy reads 0.
- R2: A control write with bus-busy=1 and start/stop=1 while idle makes SDA fall while SCL is high, and then makes SCL go low. Bus-busy reads 1 from then until the stop completes.
- R3: Each frame is nine SCL clocks. The first eight carry the data byte MSB first. SDA is released during the ninth clock. SDA never changes while SCL is high inside a frame, so no stray start or stop condition appears.
- R4: The completion flag is still 0 at the 8th SCL rise and is 1 at the 9th SCL rise. At that rise SDA is sampled into the acknowledge status: 0 if the line is low (acknowledged), 1 if it is high.
- R5: After a frame SCL stays low, and no further clocks appear, until the host acts.
- R6: A frame starts only on a flag clear that follows a data write. A clear without a preceding write, or a write without a following clear, produces no SCL clock.
- R7: Every SCL high phase lasts max(2, scl_high_cyc) clock cycles and every SCL low phase inside a frame lasts max(2, scl_low_cyc) cycles.
- R8: A control write with bus-busy=0 and start/stop=0 while parked makes SDA rise while SCL is high. Both lines are then released and bus-busy reads 0.
- R9: Any other combination of control bits has no effect. This includes bus-busy=1 with start/stop=0 while parked, and bus-busy=0 or start/stop=0 while idle.
- R10: While the engine has released SCL in a data clock but the SCL line reads low, the high-phase count does not advance. The full high phase is counted once the line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| scl_high_cyc | input | CNT_W | Requested SCL high phase length in cycles |
| scl_low_cyc | input | CNT_W | Requested SCL low phase length in cycles |
| data_wr | input | 1 | Data register write strobe |
| data_in | input | DATA_W | Byte to transmit |
| flag_clr | input | 1 | Clear strobe for the completion flag |
| ctrl_wr | input | 1 | Control bit write strobe |
| ctrl_busy | input | 1 | Bus-busy control bit value being written |
| ctrl_startstop | input | 1 | Start/stop control bit value being written |
| done_flag | output | 1 | Transfer-complete flag |
| ack_status | output | 1 | 0 = slave acknowledged, 1 = no acknowledge |
| bus_busy | output | 1 | 1 between start and completed stop |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |

## Verification
Two situations are hard to reach. One is the ordering rule for starting a frame: a clear with no write before it, and a write with no clear after it, must both leave the bus parked. The bench issues each alone while watching for clocks, and only then completes the pair. The other is clock stretching in a data clock. The bench's slave model holds the SCL line low just after a frame is released. It then checks that the high phase measured once the line rises still has its full length and that the byte still decodes. Random bytes, acknowledge choices and phase lengths, including lengths below the minimum, cover the rest.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START_A,
        S_START_B,
        S_HOLD,
        S_BIT_LOW,
        S_BIT_HIGH,
        S_STOP_A,
        S_STOP_B,
        S_STOP_C
    } tx_state_t;

    // States in which the engine leaves SCL released
    function automatic logic scl_released(input tx_state_t s);
        return (s == S_IDLE) || (s == S_START_A) || (s == S_BIT_HIGH) ||
               (s == S_STOP_B) || (s == S_STOP_C);
    endfunction

endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
    parameter int CNT_W     = 8,
    parameter int MIN_PHASE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             hold,
    output logic             expired
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_PHASE);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] eff_len;

    // Phases shorter than the minimum are stretched to it
    assign eff_len = (len < MIN_V) ? MIN_V : len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= eff_len - CNT_W'(1);
        end else if (!hold && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0) && !hold;

endmodule

// File: rtl/i2c_tx_shifter.sv
module i2c_tx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              advance,
    output logic              bit_out,
    output logic              last
);
    localparam int IDX_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] sh;
    logic [IDX_W-1:0]  idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            idx <= '0;
        end else if (load) begin
            sh  <= data;
            idx <= '0;
        end else if (advance) begin
            sh  <= {sh[DATA_W-2:0], 1'b0};
            idx <= idx + IDX_W'(1);
        end
    end

    assign bit_out = sh[DATA_W-1];
    assign last    = (idx == IDX_W'(DATA_W));

endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              wr_allow,
    input  logic              flag_clr,
    input  logic              set_done,
    input  logic              ack_val,
    input  logic              consume,
    output logic [DATA_W-1:0] data_q,
    output logic              done_flag,
    output logic              ack_status,
    output logic              armed
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q     <= '0;
            done_flag  <= 1'b0;
            ack_status <= 1'b0;
            armed      <= 1'b0;
        end else begin
            if (data_wr && wr_allow) begin
                data_q <= data_in;
            end
            if (consume) begin
                armed <= 1'b0;
            end else if (data_wr && wr_allow) begin
                armed <= 1'b1;
            end
            if (set_done) begin
                done_flag  <= 1'b1;
                ack_status <= ack_val;
            end else if (flag_clr) begin
                done_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master
    import i2c_tx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 8,
    parameter int MIN_PHASE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  scl_high_cyc,
    input  logic [CNT_W-1:0]  scl_low_cyc,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              flag_clr,
    input  logic              ctrl_wr,
    input  logic              ctrl_busy,
    input  logic              ctrl_startstop,
    output logic              done_flag,
    output logic              ack_status,
    output logic              bus_busy,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low
);
    tx_state_t         state, state_nx;
    logic              expired;
    logic              go;
    logic              last;
    logic              bit_out;
    logic              armed;
    logic              set_done;
    logic              advance;
    logic              timer_load;
    logic              timer_hold;
    logic [CNT_W-1:0]  timer_len;
    logic [DATA_W-1:0] data_q;
    logic              sda_target;
    logic              sda_q;
    logic              start_req;
    logic              stop_req;
    logic              in_frame;

    assign start_req = ctrl_wr && ctrl_busy && ctrl_startstop;
    assign stop_req  = ctrl_wr && !ctrl_busy && !ctrl_startstop;
    assign in_frame  = (state == S_BIT_LOW) || (state == S_BIT_HIGH);
    assign go        = (state == S_HOLD) && flag_clr && armed;
    assign set_done  = (state == S_BIT_LOW) && expired && last;
    assign advance   = (state == S_BIT_HIGH) && expired && !last;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (start_req) state_nx = S_START_A;
            S_START_A:  if (expired)   state_nx = S_START_B;
            S_START_B:  if (expired)   state_nx = S_HOLD;
            S_HOLD: begin
                if (go)            state_nx = S_BIT_LOW;
                else if (stop_req) state_nx = S_STOP_A;
            end
            S_BIT_LOW:  if (expired)   state_nx = S_BIT_HIGH;
            S_BIT_HIGH: if (expired)   state_nx = last ? S_HOLD : S_BIT_LOW;
            S_STOP_A:   if (expired)   state_nx = S_STOP_B;
            S_STOP_B:   if (expired)   state_nx = S_STOP_C;
            S_STOP_C:   if (expired)   state_nx = S_IDLE;
            default:                   state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Outputs
    always_comb begin
        scl_drive_low = 1'b0;
        sda_target    = 1'b0;
        unique case (state)
            S_IDLE:     begin scl_drive_low = 1'b0; sda_target = 1'b0; end
            S_START_A:  begin scl_drive_low = 1'b0; sda_target = 1'b1; end
            S_START_B:  begin scl_drive_low = 1'b1; sda_target = 1'b1; end
            S_HOLD:     begin scl_drive_low = 1'b1; sda_target = 1'b0; end
            S_BIT_LOW:  begin scl_drive_low = 1'b1; sda_target = !last && !bit_out; end
            S_BIT_HIGH: begin scl_drive_low = 1'b0; sda_target = !last && !bit_out; end
            S_STOP_A:   begin scl_drive_low = 1'b1; sda_target = 1'b1; end
            S_STOP_B:   begin scl_drive_low = 1'b0; sda_target = 1'b1; end
            S_STOP_C:   begin scl_drive_low = 1'b0; sda_target = 1'b0; end
            default:    begin scl_drive_low = 1'b0; sda_target = 1'b0; end
        endcase
    end

    // SDA trails the state by one cycle so it moves only inside SCL-low time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_q <= 1'b0;
        else        sda_q <= sda_target;
    end

    assign sda_drive_low = sda_q;
    assign bus_busy      = (state != S_IDLE);

    assign timer_load = (state_nx != state);
    assign timer_len  = scl_released(state_nx) ? scl_high_cyc : scl_low_cyc;
    assign timer_hold = (state == S_BIT_HIGH) && !scl_in;

    i2c_phase_timer #(
        .CNT_W    (CNT_W),
        .MIN_PHASE(MIN_PHASE)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (timer_load),
        .len    (timer_len),
        .hold   (timer_hold),
        .expired(expired)
    );

    i2c_tx_shifter #(
        .DATA_W(DATA_W)
    ) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (go),
        .data   (data_q),
        .advance(advance),
        .bit_out(bit_out),
        .last   (last)
    );

    i2c_host_regs #(
        .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (data_wr),
        .data_in   (data_in),
        .wr_allow  (!in_frame),
        .flag_clr  (flag_clr),
        .set_done  (set_done),
        .ack_val   (sda_in),
        .consume   (go),
        .data_q    (data_q),
        .done_flag (done_flag),
        .ack_status(ack_status),
        .armed     (armed)
    );

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (!scl_drive_low && !sda_drive_low));

    assert_sda_still_in_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_BIT_HIGH) && ($past(state) == S_BIT_HIGH)) |-> $stable(sda_drive_low));

    assert_flag_at_ninth_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> ((state == S_BIT_HIGH) && last && !scl_drive_low));

    assert_hold_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD) |-> scl_drive_low);

    assert_stop_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_STOP_C) && $past(state == S_STOP_B)) |=> !sda_drive_low);

endmodule

// File: tb/i2c_tx_master_tb.sv
module i2c_tx_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] scl_high_cyc = 8'd3;
    logic [CNT_W-1:0] scl_low_cyc = 8'd3;
    logic             data_wr = 1'b0;
    logic [7:0]       data_in = 8'h00;
    logic             flag_clr = 1'b0;
    logic             ctrl_wr = 1'b0;
    logic             ctrl_busy = 1'b0;
    logic             ctrl_startstop = 1'b0;
    logic             done_flag, ack_status, bus_busy;
    logic             scl_in, sda_in, scl_drive_low, sda_drive_low;
    logic             pull = 1'b0;
    logic             stretch = 1'b0;
    logic             ack_en = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_in = !(scl_drive_low || stretch);
    assign sda_in = !(sda_drive_low || pull);

    i2c_tx_master u_dut (
        .clk(clk), .rst_n(rst_n),
        .scl_high_cyc(scl_high_cyc), .scl_low_cyc(scl_low_cyc),
        .data_wr(data_wr), .data_in(data_in), .flag_clr(flag_clr),
        .ctrl_wr(ctrl_wr), .ctrl_busy(ctrl_busy), .ctrl_startstop(ctrl_startstop),
        .done_flag(done_flag), .ack_status(ack_status), .bus_busy(bus_busy),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
    );

    // Bus monitor and slave model
    bit         scl_p = 1, sda_p = 1;
    int         rises = 0, hi_run = 0, lo_run = 0;
    int         hi_min = 1000, hi_max = 0, lo_min = 1000, lo_max = 0;
    logic [7:0] shbyte = 0;
    bit         flag8 = 0, flag9 = 0, ack_l = 0;
    int         starts = 0, stops = 0, frames = 0;
    logic [7:0] res_byte = 0;
    bit         res_ack = 0, res_f8 = 0, res_f9 = 0;
    int         res_hmin = 0, res_hmax = 0, res_lmin = 0, res_lmax = 0;

    always @(negedge clk) begin
        if (scl_in && scl_p && !sda_in && sda_p) begin starts++; rises = 0; end
        if (scl_in && scl_p && sda_in && !sda_p) stops++;
        if (scl_in && !scl_p) begin
            if (rises >= 1 && rises <= 8) begin
                if (lo_run < lo_min) lo_min = lo_run;
                if (lo_run > lo_max) lo_max = lo_run;
            end
            rises++;
            if (rises <= 8) shbyte = {shbyte[6:0], sda_in};
            if (rises == 8) flag8 = done_flag;
            if (rises == 9) begin ack_l = sda_in; flag9 = done_flag; end
            hi_run = 0;
        end
        if (!scl_in && scl_p) begin
            if (rises >= 1 && rises <= 9) begin
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
            end
            if (rises == 8) pull = ack_en;
            if (rises == 9) begin
                pull = 1'b0;
                res_byte = shbyte; res_ack = ack_l; res_f8 = flag8; res_f9 = flag9;
                res_hmin = hi_min; res_hmax = hi_max; res_lmin = lo_min; res_lmax = lo_max;
                hi_min = 1000; hi_max = 0; lo_min = 1000; lo_max = 0;
                frames++;
                rises = 0;
            end
            lo_run = 0;
        end
        if (scl_in) hi_run++; else lo_run++;
        scl_p = scl_in;
        sda_p = sda_in;
    end

    function automatic int eff(input int x);
        return (x < 2) ? 2 : x;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_data(input logic [7:0] b);
        @(negedge clk); data_wr = 1'b1; data_in = b;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic write_ctrl(input bit busy, input bit ss);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_busy = busy; ctrl_startstop = ss;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic wait_frame(input int f0);
        int guard = 0;
        while (frames == f0 && guard < 5000) begin tick(1); guard++; end
        check("R3", "frame completed", int'(frames > f0), 1);
        tick(2);
    endtask

    task automatic check_frame(input logic [7:0] b, input bit ack, input int hl, input int ll,
                               input int st0, input int sp0);
        check("R3", "byte on SDA", res_byte, b);
        check("R3", "no start inside frame", starts, st0);
        check("R3", "no stop inside frame", stops, sp0);
        check("R4", "ack seen on line", res_ack, ack ? 0 : 1);
        check("R4", "ack_status", ack_status, ack ? 0 : 1);
        check("R4", "flag at 8th rise", res_f8, 0);
        check("R4", "flag at 9th rise", res_f9, 1);
        check("R4", "done_flag after frame", done_flag, 1);
        check("R7", "high phase min", res_hmin, eff(hl));
        check("R7", "high phase max", res_hmax, eff(hl));
        check("R7", "low phase min", res_lmin, eff(ll));
        check("R7", "low phase max", res_lmax, eff(ll));
    endtask

    task automatic run_frame(input logic [7:0] b, input bit ack, input int hl, input int ll,
                             input int stretch_n);
        int f0, st0, sp0;
        scl_high_cyc = CNT_W'(hl);
        scl_low_cyc  = CNT_W'(ll);
        ack_en = ack;
        f0 = frames; st0 = starts; sp0 = stops;
        write_data(b);
        clear_flag();
        if (stretch_n > 0) begin
            stretch = 1'b1;
            tick(stretch_n);
            stretch = 1'b0;
        end
        wait_frame(f0);
        check_frame(b, ack, hl, ll, st0, sp0);
        // R5: parked with SCL low and no clocks
        tick(40);
        check("R5", "no clocks while parked", frames, f0 + 1);
        check("R5", "SCL held low", scl_in, 0);
        check("R2", "bus busy mid-transaction", bus_busy, 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int f0, sp0, st0;
        void'($urandom(32'd20240611));
        tick(5);
        // R1: reset state
        check("R1", "SCL released", scl_in, 1);
        check("R1", "SDA released", sda_in, 1);
        check("R1", "done_flag", done_flag, 0);
        check("R1", "ack_status", ack_status, 0);
        check("R1", "bus_busy", bus_busy, 0);
        rst_n = 1'b1;
        tick(3);

        // R9: invalid control writes in idle
        write_ctrl(1'b0, 1'b0);
        write_ctrl(1'b1, 1'b0);
        write_ctrl(1'b0, 1'b1);
        tick(20);
        check("R9", "no start from idle", starts, 0);
        check("R9", "still idle", bus_busy, 0);
        check("R9", "SCL released in idle", scl_in, 1);

        // R2: start
        write_ctrl(1'b1, 1'b1);
        tick(20);
        check("R2", "start condition seen", starts, 1);
        check("R2", "bus busy", bus_busy, 1);
        check("R2", "SCL low after start", scl_in, 0);
        check("R2", "no stop", stops, 0);

        // Directed frames
        run_frame(8'hA4, 1'b1, 3, 3, 0);
        run_frame(8'h00, 1'b1, 0, 1, 0);
        run_frame(8'hFF, 1'b0, 1, 0, 0);
        run_frame(8'h5A, 1'b1, 5, 2, 0);

        // R6: clear without write, then write without clear
        f0 = frames;
        clear_flag();
        tick(60);
        check("R6", "clear alone gives no clocks", frames, f0);
        check("R6", "SCL low after lone clear", scl_in, 0);
        write_data(8'h3C);
        tick(60);
        check("R6", "write alone gives no clocks", frames, f0);
        check("R6", "SCL low after lone write", scl_in, 0);
        st0 = starts; sp0 = stops;
        ack_en = 1'b1;
        clear_flag();
        wait_frame(f0);
        check("R6", "frame after write then clear", res_byte, 8'h3C);
        check_frame(8'h3C, 1'b1, 5, 2, st0, sp0);

        // R9: invalid control write while parked
        sp0 = stops;
        write_ctrl(1'b1, 1'b0);
        tick(30);
        check("R9", "no stop from busy=1 ss=0", stops, sp0);
        check("R9", "still busy", bus_busy, 1);

        // R10: slave stretches the first data clock
        run_frame(8'hC3, 1'b1, 3, 3, 25);
        check("R10", "byte after stretch", res_byte, 8'hC3);
        check("R10", "full high phase after stretch", res_hmin, 3);

        // Random frames
        for (int i = 0; i < 24; i++) begin
            logic [7:0] b;
            bit a;
            int hl, ll;
            b  = 8'($urandom);
            a  = 1'($urandom % 2);
            hl = int'($urandom % 6);
            ll = int'($urandom % 6);
            run_frame(b, a, hl, ll, 0);
        end

        // R8: stop
        scl_high_cyc = 8'd3; scl_low_cyc = 8'd3;
        sp0 = stops;
        write_ctrl(1'b0, 1'b0);
        tick(30);
        check("R8", "stop condition seen", stops, sp0 + 1);
        check("R8", "bus idle", bus_busy, 0);
        check("R8", "SCL released", scl_in, 1);
        check("R8", "SDA released", sda_in, 1);

        // Second transaction after a stop
        st0 = starts;
        write_ctrl(1'b1, 1'b1);
        tick(20);
        check("R2", "second start", starts, st0 + 1);
        run_frame(8'h81, 1'b0, 2, 4, 0);
        sp0 = stops;
        write_ctrl(1'b0, 1'b0);
        tick(40);
        check("R8", "second stop", stops, sp0 + 1);
        check("R8", "idle after second stop", bus_busy, 0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule